// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block lets synchronous logic use an external asynchronous static RAM that is one bit wide, has 22 address lines, separate data-in and data-out pins, and active-low chip-select, write-enable and output-enable strobes. The user side offers one request at a time: a request carries a write flag, an address and a write bit. When the access is complete the block returns a one-cycle response pulse, and for a read that pulse comes with the bit it sampled.

All strobe timing comes from cycle counts. Each minimum time of the RAM is a parameter in nanoseconds. Each is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. An access is built from four phases. First the address is set up while every strobe is high. Then comes the strobe window. Then the strobes return high while the address and data are held. Then the block goes idle. So the address never moves while a write is in progress, and the address is always ready before chip-select falls.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops from the accepting edge until the access has finished, which is the only back-pressure. The requester must keep `req_valid` and its fields stable until the request is taken. The response has no back-pressure: `rsp_valid` is a pulse one cycle long and must be consumed when it appears.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and after it is released, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all high, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the access ends. A `req_valid` held high across several accesses gives exactly one response per acceptance.
- R3: A write drives chip-select low, write-enable low and output-enable high. A read drives chip-select low, write-enable high and output-enable low. Write-enable and output-enable are never low together.
- R4: While chip-select and write-enable are both low, `mem_addr` and `mem_din` do not change.
- R5: `mem_addr` already holds its final value in the cycle before chip-select falls. That setup lasts for at least ceil(T_AS/T_CLK) cycles, and never less than one.
- R6: The write pulse lasts at least max(T_WP, T_CW, T_DW) nanoseconds, counted in whole clock cycles.
- R7: After write-enable and chip-select rise, `mem_addr` and `mem_din` stay unchanged for at least max(1, ceil(T_DH/T_CLK)) cycles.
- R8: The read window, with chip-select and output-enable low, lasts at least T_AA, T_ACS and T_OE. `mem_dout` is sampled at the edge that ends the window, and a read response returns the last bit written to that address, or 0 for an address never written.
- R9: Between the end of one strobe window and the start of the next, all three strobes stay high for at least three cycles: the recovery, idle and setup phases.
- R10: `rsp_valid` is a single-cycle pulse. With default parameters and an 8 ns clock it rises on the 3rd rising edge after the accepting edge for a write, and on the 4th for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse when an access ends |
| rsp_rdata | output | 1 | Bit read, valid with `rsp_valid` after a read |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_din | output | 1 | RAM data input |
| mem_dout | input | 1 | RAM data output |
| mem_cs_n | output | 1 | RAM chip-select, active low |
| mem_we_n | output | 1 | RAM write-enable, active low |
| mem_oe_n | output | 1 | RAM output-enable, active low |

## Verification
The hardest case to reach from the ports is a read sampled too early. A real RAM only shows stale or undefined data in that case, which a simple model hides. The RAM model in the bench therefore counts how long chip-select and output-enable have been low, and returns the inverted stored bit until the access time in nanoseconds has passed. Any shortened read window then shows up as a data mismatch. A second hard case is back-to-back acceptance, where the idle phase lasts only one cycle. A directed phase holds `req_valid` high for many cycles so that each new request is taken on the first idle edge. Random reads and writes are aimed at a small set of addresses at both ends of the address space, so that reads often hit recently written locations.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles still missing from a full cycle-time after fixed phases, floor one.
  function automatic int unsigned fill_cycles(input int unsigned total,
                                              input int unsigned used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  // A phase loaded with N lasts exactly N cycles: N-1 is stored, expiry at 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expire = (cnt == '0);

  // R6: once loaded, the count falls by one each cycle, so no phase is cut short
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned AS_CYC   = 1,
  parameter int unsigned WR_CYC   = 1,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             accept,
  input  logic             expire,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             sample,
  output logic             rsp_valid,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n
);

  seq_state_e state, nxt;
  logic       is_wr, wr_nxt, done;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && (state == ST_IDLE);
  assign wr_nxt    = (state == ST_IDLE) ? req_write : is_wr;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    sample   = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          nxt      = ST_SETUP;
          load     = 1'b1;
          load_val = CNT_W'(AS_CYC);
        end
      end
      ST_SETUP: begin
        if (expire) begin
          nxt      = ST_STROBE;
          load     = 1'b1;
          load_val = is_wr ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
        end
      end
      ST_STROBE: begin
        if (expire) begin
          nxt      = ST_RECOVER;
          load     = 1'b1;
          load_val = is_wr ? CNT_W'(HOLD_CYC) : CNT_W'(1);
          sample   = !is_wr;
        end
      end
      ST_RECOVER: begin
        if (expire) begin
          nxt  = ST_IDLE;
          done = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      rsp_valid <= 1'b0;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
    end else begin
      state     <= nxt;
      is_wr     <= wr_nxt;
      rsp_valid <= done;
      cs_n      <= (nxt != ST_STROBE);
      we_n      <= !((nxt == ST_STROBE) && wr_nxt);
      oe_n      <= !((nxt == ST_STROBE) && !wr_nxt);
    end
  end

  // R3: the RAM output is never enabled while a write is in progress
  p_we_oe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  // R2: an accepted request takes the ready flag away on the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: when chip-select rises, all strobes stay high for the following cycle
  p_recover_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (cs_n && we_n && oe_n));

  // R10: the response lasts one cycle
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              sample,
  input  logic              mem_dout,
  input  logic              cs_n,
  input  logic              we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  output logic              rsp_rdata
);

  // Address and data change only on acceptance, which happens in idle with
  // every strobe high; they then hold through setup, strobe and recovery.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_din  <= 1'b0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_din  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= 1'b0;
    end else if (sample) begin
      rsp_rdata <= mem_dout;
    end
  end

  // R4: the address does not move inside a write pulse
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (cs_n || we_n || $stable(mem_addr)));

  // R5: the address is already settled when chip-select falls
  p_addr_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 22,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_DH_NS       = 0,
  parameter int unsigned T_WC_NS       = 10,
  parameter int unsigned T_WP_NS       = 7,
  parameter int unsigned T_CW_NS       = 7,
  parameter int unsigned T_AW_NS       = 7,
  parameter int unsigned T_DW_NS       = 5,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_ACS_NS      = 10,
  parameter int unsigned T_OE_NS       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  input  logic              mem_dout,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int unsigned AS_CYC   = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = ns_to_cycles(T_DH_NS, CLK_PERIOD_NS);
  localparam int unsigned WPULSE   = max_u(max_u(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                                 ns_to_cycles(T_CW_NS, CLK_PERIOD_NS)),
                                           max_u(ns_to_cycles(T_DW_NS, CLK_PERIOD_NS),
                                                 fill_cycles(ns_to_cycles(T_AW_NS, CLK_PERIOD_NS), AS_CYC)));
  localparam int unsigned WR_CYC   = max_u(WPULSE,
                                           fill_cycles(ns_to_cycles(T_WC_NS, CLK_PERIOD_NS),
                                                       AS_CYC + HOLD_CYC));
  localparam int unsigned RWIN     = max_u(max_u(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                                 ns_to_cycles(T_ACS_NS, CLK_PERIOD_NS)),
                                           ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_CYC   = max_u(RWIN,
                                           fill_cycles(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                                       AS_CYC + 1));
  localparam int unsigned MAX_CYC  = max_u(max_u(AS_CYC, HOLD_CYC), max_u(WR_CYC, RD_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             accept, load, expire, sample;
  logic [CNT_W-1:0] load_val;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .AS_CYC   (AS_CYC),
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .expire    (expire),
    .load      (load),
    .load_val  (load_val),
    .sample    (sample),
    .rsp_valid (rsp_valid),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n)
  );

  sram_data_path #(.ADDR_W(ADDR_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sample    (sample),
    .mem_dout  (mem_dout),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_din   (mem_din),
    .rsp_rdata (rsp_rdata)
  );

  // R1: with reset released and no access running, all strobes are high
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !$past(req_valid && req_ready)) |-> (mem_cs_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

  localparam int CLK_NS = 8;
  localparam int T_WP = 7, T_CW = 7, T_DW = 5, T_AA = 10, T_ACS = 10, T_OE = 5;
  localparam int LAT_WR = 3, LAT_RD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [21:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_rdata;
  logic [21:0] mem_addr;
  logic        mem_din, mem_cs_n, mem_we_n, mem_oe_n;
  logic        mem_dout = 1'b0;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  bit ram_arr [int unsigned];
  bit sb      [int unsigned];
  int rd_cyc = 0;

  function automatic bit ram_bit(input logic [21:0] a);
    return ram_arr.exists(int'(a)) ? ram_arr[int'(a)] : 1'b0;
  endfunction

  function automatic bit sb_bit(input logic [21:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) ram_arr[int'(mem_addr)] = mem_din;
    if (!mem_cs_n && mem_we_n && !mem_oe_n) rd_cyc <= rd_cyc + 1;
    else rd_cyc <= 0;
  end

  // ---------------- pin monitor (negedge) ----------------
  logic        p_cs = 1'b1, p_we = 1'b1, p_wr_act = 1'b0, p_rd_act = 1'b0;
  logic [21:0] p_addr = '0, w_addr = '0;
  logic        w_din = 1'b0;
  int          wr_len = 0, rd_len = 0, hi_len = 0;
  bit          wr_moved = 0, combo_bad = 0, seen_access = 0;

  always @(negedge clk) begin
    logic wr_act, rd_act, ok_time;
    wr_act = !mem_cs_n && !mem_we_n;
    rd_act = !mem_cs_n && mem_we_n && !mem_oe_n;
    // Model output: inverted (stale) data until the access times have elapsed
    ok_time = ((rd_cyc + 1) * CLK_NS >= T_AA) && ((rd_cyc + 1) * CLK_NS >= T_ACS)
              && ((rd_cyc + 1) * CLK_NS >= T_OE);
    mem_dout = rd_act ? (ok_time ? ram_bit(mem_addr) : ~ram_bit(mem_addr)) : 1'b0;
    if (rst_n) begin
      if (!mem_we_n && !mem_oe_n) combo_bad = 1;
      if (p_cs && !mem_cs_n) begin
        chk(mem_addr == p_addr, "R5", "address moved at chip-select fall",
            int'(mem_addr), int'(p_addr));
        if (seen_access)
          chk(hi_len >= 3, "R9", "strobe-high gap cycles", hi_len, 3);
        hi_len = 0;
        seen_access = 1;
      end
      if (wr_act) begin
        if (wr_len == 0) begin w_addr = mem_addr; w_din = mem_din; end
        else if (mem_addr != w_addr || mem_din != w_din) wr_moved = 1;
        wr_len++;
      end
      if (p_wr_act && !wr_act) begin
        chk(wr_len * CLK_NS >= T_WP && wr_len * CLK_NS >= T_CW && wr_len * CLK_NS >= T_DW,
            "R6", "write pulse ns", wr_len * CLK_NS, T_WP);
        chk(!wr_moved, "R4", "address/data changed in write pulse", int'(wr_moved), 0);
        chk(mem_addr == w_addr && mem_din == w_din, "R7", "hold after write",
            int'(mem_addr), int'(w_addr));
        chk(!combo_bad, "R3", "write-enable with output-enable low", int'(combo_bad), 0);
        chk(mem_oe_n, "R3", "output-enable after write", int'(mem_oe_n), 1);
        wr_len = 0; wr_moved = 0; combo_bad = 0;
      end
      if (rd_act) rd_len++;
      if (p_rd_act && !rd_act) begin
        chk(rd_len * CLK_NS >= T_AA && rd_len * CLK_NS >= T_OE, "R8", "read window ns",
            rd_len * CLK_NS, T_AA);
        chk(!combo_bad, "R3", "read with write-enable low", int'(combo_bad), 0);
        rd_len = 0; combo_bad = 0;
      end
      if (mem_cs_n && mem_we_n && mem_oe_n) hi_len++;
    end
    p_cs = mem_cs_n; p_we = mem_we_n; p_addr = mem_addr;
    p_wr_act = wr_act; p_rd_act = rd_act;
  end

  // ---------------- stimulus ----------------
  task automatic do_op(input bit wr, input logic [21:0] a, input bit d);
    int n;
    bit exp;
    while (!req_ready) @(negedge clk);
    exp = sb_bit(a);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(!req_ready, "R2", "ready while busy", int'(req_ready), 0);
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == (wr ? LAT_WR : LAT_RD) + 1, "R10", wr ? "write latency" : "read latency",
        n - 1, wr ? LAT_WR : LAT_RD);
    if (wr) sb[int'(a)] = d;
    else chk(rsp_rdata == exp, "R8", "read data", int'(rsp_rdata), int'(exp));
    @(negedge clk);
    chk(!rsp_valid, "R10", "response pulse length", int'(rsp_valid), 0);
  endtask

  initial begin
    int unsigned seed_val;
    int acc, rsp;
    seed_val = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1", "strobes in reset", int'(mem_cs_n), 1);
    chk(req_ready && !rsp_valid, "R1", "ready/response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1", "strobes after reset", int'(mem_we_n), 1);

    // Directed corners: never-written address, both address ends, overwrite
    do_op(1'b0, 22'h000123, 1'b0);
    do_op(1'b1, 22'h000000, 1'b1);
    do_op(1'b0, 22'h000000, 1'b0);
    do_op(1'b1, 22'h3FFFFF, 1'b1);
    do_op(1'b0, 22'h3FFFFF, 1'b0);
    do_op(1'b1, 22'h000000, 1'b0);
    do_op(1'b0, 22'h000000, 1'b0);
    do_op(1'b0, 22'h3FFFFF, 1'b0);

    // R2: valid held high over many cycles, one response per acceptance
    acc = 0; rsp = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 22'h000009; req_wdata = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (rsp_valid) rsp++;
      if (req_ready && req_valid) acc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (rsp_valid) rsp++;
      @(negedge clk);
    end
    sb[9] = 1'b1;
    chk(acc == rsp, "R2", "responses vs acceptances", rsp, acc);
    chk(acc == 4, "R2", "back-to-back acceptances in 16 cycles", acc, 4);
    do_op(1'b0, 22'h000009, 1'b0);

    // Random mix aimed at a small window at both ends of the address space
    for (int i = 0; i < 200; i++) begin
      logic [21:0] a;
      a = 22'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) a = a | 22'h3FFFF0;
      do_op($urandom_range(0, 1) == 1, a, $urandom_range(0, 1) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule